// File: doc/BRIEF.md
# Fetch Fault Carrier Pipeline

This block is a narrow in-order slice of a processor front end and retirement path. Fetch issues one PC per cycle and takes back an instruction word in the same cycle, together with a fault flag, a fault code and a flag for a bad or uncacheable address. Every fetched word becomes an entry in an eight-deep in-order queue, tagged with a sequence number. A stub execute path finishes an ordinary entry a fixed number of cycles after dispatch. A no-operation entry is ready to retire as soon as it is dispatched.

When a fetch faults, the fetched word is dropped and a no-operation entry takes its place. That entry carries the fault code and gets the next sequence number, so the fault stays in program order with the other instructions. Fetch then parks in a trap-pending state. When the carrier entry reaches the head of the queue, every older instruction has already retired. Commit then raises a one-cycle trap with the code, the faulting PC and the predicted next PC. It empties the queue and redirects fetch to the trap vector, and fetch restarts there after a one-cycle bubble.

Top module: `fault_carrier_pipe`

## Requirements
- R1: While reset is held, `fetchPc` equals `RESET_PC` (default 0x0000_1000) and `commitValid` and `trapValid` are both 0. The first entry fetched after reset gets sequence number 0.
- R2: Fetch presents at most one PC per cycle. Each fetch that does not fault moves the fetch PC forward by `INST_BYTES` (4).
- R3: A fetch with `fetchFault`=1 creates an entry that carries `fetchFaultCode`. It takes the next sequence number from the counter shared with normal fetches, and that number appears on `trapSeq`.
- R4: A fetch with `fetchBadAddr`=1 creates a carrier entry with code `MCHK_CODE` (default 4'hF). This holds whether or not `fetchFault` is also set.
- R5: After a faulting fetch, `fetchValid` stays 0 until the trap for that entry has been taken.
- R6: A trap fires only when the carrier entry is at the head of the queue, so all older entries have retired first. It lasts exactly one cycle and never coincides with `commitValid`. It shows the faulting PC on `trapPc` and that PC plus 4 on `trapNextPc`.
- R7: The trap empties the queue and redirects fetch. The cycle after the trap has no fetch, and the cycle after that fetches at `TRAP_VEC` (default 0x0000_0100).
- R8: An entry whose word equals `NOP_WORD` (0x0000_0013) skips execute and can retire in the cycle after it was fetched. A carrier entry can likewise trap in the cycle after it was fetched. An ordinary entry can retire `EXE_LAT`+1 cycles after its fetch (default 11).
- R9: When 8 entries are outstanding, `fetchValid` is 0.
- R10: Ordinary entries retire strictly in fetch order, one per cycle at most, each exactly once. The retire cycle is the later of two cycles: the cycle the entry becomes ready, and one cycle after the previous entry retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | output | 1 | A fetch is issued at `fetchPc` this cycle |
| fetchPc | output | ADDR_W | Fetch address |
| instWord | input | WORD_W | Word returned for `fetchPc` in the same cycle |
| fetchFault | input | 1 | The fetch this cycle faulted |
| fetchFaultCode | input | CODE_W | Code of that fault |
| fetchBadAddr | input | 1 | Fetch address flagged bad or uncacheable |
| commitValid | output | 1 | The head entry retires this cycle |
| commitPc | output | ADDR_W | PC of the retiring entry |
| commitSeq | output | SEQ_W | Sequence number of the retiring entry |
| trapValid | output | 1 | One-cycle trap from a carrier entry at the head |
| trapCode | output | CODE_W | Fault code carried by that entry |
| trapPc | output | ADDR_W | PC of the faulting fetch |
| trapNextPc | output | ADDR_W | Predicted next PC of the carrier entry |
| trapSeq | output | SEQ_W | Sequence number of the carrier entry |

## Verification
The interesting overlap is a retire at the head in the same cycle as a fetch at the tail, when the queue is at or next to full. The full-queue stall must depend only on the count at the start of the cycle. The long default execute latency keeps the queue at its limit for most of the random run, so these same-cycle pairs happen often. The bench predicts the exact retire cycle of every entry and the exact cycle of every fetch, so a stall that comes one cycle early or late shows up as a mismatch. A second overlap is a fault on the first fetch after a redirect into an empty queue. The bench provokes it on purpose and checks that the trap comes one cycle after that fetch.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

  typedef enum logic [1:0] {
    FS_RUN    = 2'd0,
    FS_TRAP   = 2'd1,
    FS_BUBBLE = 2'd2
  } fetchState_e;

  // strobes from fetch control to the datapath
  typedef struct packed {
    logic push;       // write a new entry at the tail
    logic pushFault;  // that entry is a fault carrier
    logic stepPc;     // advance the fetch PC sequentially
    logic loadVec;    // load the trap vector into the fetch PC
  } fetchStrobe_t;

endpackage

// File: rtl/ffc_fetch_ctrl.sv
module ffc_fetch_ctrl
  import ffc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         queueFull,
  input  logic         faultIn,
  input  logic         trapFire,
  output fetchStrobe_t strobe,
  output logic         fetchValid
);

  fetchState_e state, stateNext;

  always_comb begin
    fetchValid       = (state == FS_RUN) && !queueFull;
    strobe.push      = fetchValid;
    strobe.pushFault = fetchValid && faultIn;
    strobe.stepPc    = fetchValid && !faultIn;
    strobe.loadVec   = trapFire;

    stateNext = state;
    case (state)
      FS_RUN:    if (fetchValid && faultIn) stateNext = FS_TRAP;
      FS_TRAP:   if (trapFire) stateNext = FS_BUBBLE;
      FS_BUBBLE: stateNext = FS_RUN;
      default:   stateNext = FS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= FS_RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ffc_datapath.sv
module ffc_datapath
  import ffc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int CODE_W     = 4,
  parameter int SEQ_W      = 16,
  parameter int DEPTH      = 8,
  parameter int EXE_LAT    = 10,
  parameter int INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC  = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] TRAP_VEC  = 32'h0000_0100,
  parameter logic [WORD_W-1:0] NOP_WORD  = 32'h0000_0013,
  parameter logic [CODE_W-1:0] MCHK_CODE = 4'hF
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetchStrobe_t        strobe,
  input  logic [WORD_W-1:0]   instWord,
  input  logic [CODE_W-1:0]   faultCodeIn,
  input  logic                badAddr,
  output logic                queueFull,
  output logic                trapFire,
  output logic [ADDR_W-1:0]   fetchPc,
  output logic                commitValid,
  output logic [ADDR_W-1:0]   commitPc,
  output logic [SEQ_W-1:0]    commitSeq,
  output logic [CODE_W-1:0]   trapCode,
  output logic [ADDR_W-1:0]   trapPc,
  output logic [ADDR_W-1:0]   trapNextPc,
  output logic [SEQ_W-1:0]    trapSeq
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LAT_W = $clog2(EXE_LAT + 1);

  logic [ADDR_W-1:0] entPc    [DEPTH];
  logic [SEQ_W-1:0]  entSeq   [DEPTH];
  logic              entFault [DEPTH];
  logic [CODE_W-1:0] entCode  [DEPTH];
  logic [LAT_W-1:0]  entTimer [DEPTH];

  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] count;
  logic [SEQ_W-1:0] seqCtr;
  logic [ADDR_W-1:0] pcReg;

  logic headValid, headReady, retire, skipExec;
  logic [CODE_W-1:0] pushCode;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign queueFull = (count == CNT_W'(DEPTH));
  assign headValid = (count != '0);
  assign headReady = (entTimer[headPtr] == '0);
  assign trapFire  = headValid && headReady && entFault[headPtr];
  assign retire    = headValid && headReady && !entFault[headPtr];
  assign skipExec  = strobe.pushFault || (instWord == NOP_WORD);
  assign pushCode  = badAddr ? MCHK_CODE : faultCodeIn;

  // entry storage and stub execute timers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        entPc[i]    <= '0;
        entSeq[i]   <= '0;
        entFault[i] <= 1'b0;
        entCode[i]  <= '0;
        entTimer[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.push && tailPtr == PTR_W'(i)) begin
          entPc[i]    <= pcReg;
          entSeq[i]   <= seqCtr;
          entFault[i] <= strobe.pushFault;
          entCode[i]  <= strobe.pushFault ? pushCode : '0;
          entTimer[i] <= skipExec ? '0 : LAT_W'(EXE_LAT);
        end else if (entTimer[i] != '0) begin
          entTimer[i] <= entTimer[i] - 1'b1;
        end
      end
    end
  end

  // queue pointers, fetch PC and sequence counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
      seqCtr  <= '0;
      pcReg   <= RESET_PC;
    end else begin
      if (trapFire) begin
        headPtr <= '0;
        tailPtr <= '0;
        count   <= '0;
      end else begin
        if (strobe.push) tailPtr <= ptrInc(tailPtr);
        if (retire)      headPtr <= ptrInc(headPtr);
        count <= count + CNT_W'(strobe.push) - CNT_W'(retire);
      end
      if (strobe.push) seqCtr <= seqCtr + 1'b1;
      if (strobe.loadVec)     pcReg <= TRAP_VEC;
      else if (strobe.stepPc) pcReg <= pcReg + ADDR_W'(INST_BYTES);
    end
  end

  assign fetchPc     = pcReg;
  assign commitValid = retire;
  assign commitPc    = entPc[headPtr];
  assign commitSeq   = entSeq[headPtr];
  assign trapCode    = entCode[headPtr];
  assign trapPc      = entPc[headPtr];
  assign trapNextPc  = entPc[headPtr] + ADDR_W'(INST_BYTES);
  assign trapSeq     = entSeq[headPtr];

endmodule

// File: rtl/fault_carrier_pipe.sv
module fault_carrier_pipe
  import ffc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int CODE_W     = 4,
  parameter int SEQ_W      = 16,
  parameter int DEPTH      = 8,
  parameter int EXE_LAT    = 10,
  parameter int INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC  = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] TRAP_VEC  = 32'h0000_0100,
  parameter logic [WORD_W-1:0] NOP_WORD  = 32'h0000_0013,
  parameter logic [CODE_W-1:0] MCHK_CODE = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              fetchValid,
  output logic [ADDR_W-1:0] fetchPc,
  input  logic [WORD_W-1:0] instWord,
  input  logic              fetchFault,
  input  logic [CODE_W-1:0] fetchFaultCode,
  input  logic              fetchBadAddr,
  output logic              commitValid,
  output logic [ADDR_W-1:0] commitPc,
  output logic [SEQ_W-1:0]  commitSeq,
  output logic              trapValid,
  output logic [CODE_W-1:0] trapCode,
  output logic [ADDR_W-1:0] trapPc,
  output logic [ADDR_W-1:0] trapNextPc,
  output logic [SEQ_W-1:0]  trapSeq
);

  fetchStrobe_t strobe;
  logic queueFull, trapFire;

  ffc_fetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .queueFull  (queueFull),
    .faultIn    (fetchFault || fetchBadAddr),
    .trapFire   (trapFire),
    .strobe     (strobe),
    .fetchValid (fetchValid)
  );

  ffc_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CODE_W(CODE_W), .SEQ_W(SEQ_W),
    .DEPTH(DEPTH), .EXE_LAT(EXE_LAT), .INST_BYTES(INST_BYTES),
    .RESET_PC(RESET_PC), .TRAP_VEC(TRAP_VEC), .NOP_WORD(NOP_WORD),
    .MCHK_CODE(MCHK_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .instWord    (instWord),
    .faultCodeIn (fetchFaultCode),
    .badAddr     (fetchBadAddr),
    .queueFull   (queueFull),
    .trapFire    (trapFire),
    .fetchPc     (fetchPc),
    .commitValid (commitValid),
    .commitPc    (commitPc),
    .commitSeq   (commitSeq),
    .trapCode    (trapCode),
    .trapPc      (trapPc),
    .trapNextPc  (trapNextPc),
    .trapSeq     (trapSeq)
  );

  assign trapValid = trapFire;

endmodule

// File: rtl/fault_carrier_pipe_chk.sv
module fault_carrier_pipe_chk #(
  parameter int ADDR_W     = 32,
  parameter int SEQ_W      = 16,
  parameter int DEPTH      = 8,
  parameter int INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 32'h0000_0100
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchValid,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              fetchFault,
  input logic              fetchBadAddr,
  input logic              commitValid,
  input logic [SEQ_W-1:0]  commitSeq,
  input logic              trapValid,
  input logic [SEQ_W-1:0]  trapSeq
);

  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ;
  logic             pending;
  logic [SEQ_W-1:0] doneCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ     <= '0;
      pending <= 1'b0;
      doneCnt <= '0;
    end else begin
      if (trapValid) occ <= '0;
      else occ <= occ + OCC_W'(fetchValid) - OCC_W'(commitValid);
      if (fetchValid && (fetchFault || fetchBadAddr)) pending <= 1'b1;
      else if (trapValid) pending <= 1'b0;
      if (commitValid || trapValid) doneCnt <= doneCnt + 1'b1;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchFault && !fetchBadAddr) |=>
      (fetchPc == $past(fetchPc) + ADDR_W'(INST_BYTES)));

  p_trap_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !fetchValid);

  p_trap_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !trapValid);

  p_trap_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(trapValid && commitValid));

  p_bubble_r7: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !fetchValid);

  p_redirect_r7: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> ##2 (fetchValid && fetchPc == TRAP_VEC));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(DEPTH)) |-> !fetchValid);

  p_order_r10: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (commitSeq == doneCnt));

  p_trap_seq_r3: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> (trapSeq == doneCnt));

endmodule

bind fault_carrier_pipe fault_carrier_pipe_chk #(
  .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .DEPTH(DEPTH),
  .INST_BYTES(INST_BYTES), .TRAP_VEC(TRAP_VEC)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fetchValid   (fetchValid),
  .fetchPc      (fetchPc),
  .fetchFault   (fetchFault),
  .fetchBadAddr (fetchBadAddr),
  .commitValid  (commitValid),
  .commitSeq    (commitSeq),
  .trapValid    (trapValid),
  .trapSeq      (trapSeq)
);

// File: tb/sim_fault_carrier_pipe.sv
`timescale 1ns/1ps
module sim_fault_carrier_pipe;

  localparam int EXE_LAT = 10;
  localparam int DEPTH   = 8;
  localparam logic [31:0] RESET_PC = 32'h0000_1000;
  localparam logic [31:0] TRAP_VEC = 32'h0000_0100;
  localparam logic [31:0] NOP_WORD = 32'h0000_0013;
  localparam logic [3:0]  MCHK     = 4'hF;
  localparam int NCYC = 6000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid;
  logic [31:0] fetchPc;
  logic [31:0] instWord = '0;
  logic fetchFault = 1'b0;
  logic [3:0] fetchFaultCode = '0;
  logic fetchBadAddr = 1'b0;
  logic commitValid;
  logic [31:0] commitPc;
  logic [15:0] commitSeq;
  logic trapValid;
  logic [3:0] trapCode;
  logic [31:0] trapPc, trapNextPc;
  logic [15:0] trapSeq;

  always #2.5 clk = ~clk;

  fault_carrier_pipe u0 (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .instWord(instWord), .fetchFault(fetchFault), .fetchFaultCode(fetchFaultCode),
    .fetchBadAddr(fetchBadAddr), .commitValid(commitValid), .commitPc(commitPc),
    .commitSeq(commitSeq), .trapValid(trapValid), .trapCode(trapCode),
    .trapPc(trapPc), .trapNextPc(trapNextPc), .trapSeq(trapSeq)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected queue model
  logic [31:0] qPc    [16];
  int          qSeq   [16];
  bit          qFlt   [16];
  logic [3:0]  qCode  [16];
  int          qExp   [16];
  bit          qNop   [16];
  bit          qBad   [16];
  int qRd = 0, qWr = 0, qSize = 0;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int readyCycle(input int fetchCyc, input bit skip);
    return fetchCyc + 1 + (skip ? 0 : EXE_LAT);
  endfunction

  typedef enum {B_RUN, B_WAIT, B_BUB} bState_e;

  initial begin
    bState_e bs = B_RUN;
    logic [31:0] expPc = RESET_PC;
    int seqCnt = 0, lastExp = 0, nTraps = 0, nCommits = 0, nMchk = 0, nFull = 0;
    bit firstAfterReset = 1, firstAfterTrap = 0;
    void'($urandom(32'd2024));

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(commitValid == 0, "R1 commitValid in reset", commitValid, 0);
    chk(trapValid == 0, "R1 trapValid in reset", trapValid, 0);
    chk(fetchPc == RESET_PC, "R1 fetchPc in reset", fetchPc, RESET_PC);
    rstN = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      bit expFetch, evt, doTrap;
      bState_e nextBs;
      expFetch = (bs == B_RUN) && (qSize < DEPTH);
      if (qSize == DEPTH) nFull++;
      nextBs = (bs == B_BUB) ? B_RUN : bs;
      doTrap = 0;

      // retire / trap side
      evt = (qSize > 0) && (qExp[qRd] == cyc);
      if (evt && qFlt[qRd]) begin
        chk(trapValid == 1, "R6 trap at head", trapValid, 1);
        chk(commitValid == 0, "R6 no commit with trap", commitValid, 0);
        chk(trapCode == qCode[qRd], qBad[qRd] ? "R4 machine-check code" : "R3 carried code",
            trapCode, qCode[qRd]);
        chk(trapSeq == 16'(qSeq[qRd]), "R3 carrier seq", trapSeq, qSeq[qRd]);
        chk(trapPc == qPc[qRd], "R6 trapPc", trapPc, qPc[qRd]);
        chk(trapNextPc == qPc[qRd] + 4, "R6 trapNextPc", trapNextPc, qPc[qRd] + 4);
        if (qBad[qRd]) nMchk++;
        doTrap = 1;
      end else if (evt) begin
        chk(commitValid == 1, qNop[qRd] ? "R8 nop retire cycle" : "R10 retire cycle", commitValid, 1);
        chk(trapValid == 0, "R6 no trap on ordinary", trapValid, 0);
        chk(commitPc == qPc[qRd], "R10 commit pc", commitPc, qPc[qRd]);
        chk(commitSeq == 16'(qSeq[qRd]), "R10 commit seq", commitSeq, qSeq[qRd]);
        qRd = (qRd + 1) % 16; qSize--; nCommits++;
      end else begin
        chk(commitValid == 0 && trapValid == 0, "R10 idle retire port",
            {commitValid, trapValid}, 0);
      end

      // fetch side
      chk(fetchValid == expFetch,
          (qSize == DEPTH || (evt && !doTrap && qSize == DEPTH - 1)) ? "R9 full stall" :
          (bs == B_WAIT) ? "R5 trap pending" : (bs == B_BUB) ? "R7 bubble" : "R2 fetch",
          fetchValid, expFetch);
      if (fetchValid && expFetch) begin
        int r;
        bit f, b, nop, skip;
        logic [3:0] code;
        logic [31:0] w;
        chk(fetchPc == expPc, firstAfterTrap ? "R7 redirect pc" :
            firstAfterReset ? "R1 reset pc" : "R2 sequential pc", fetchPc, expPc);
        r = int'($urandom % 100);
        f = (r < 3) || (r == 5);
        b = (r == 3) || (r == 4) || (r == 5);
        code = 4'($urandom % 15);
        w = ($urandom % 4 == 0) ? NOP_WORD : ($urandom | 32'h8000_0000);
        if (firstAfterReset) begin w = NOP_WORD; f = 0; b = 0; end
        else if (firstAfterTrap && nTraps == 1) begin w = 32'hDEAD_0001; f = 0; b = 0; end
        else if (firstAfterTrap && nTraps == 2) begin f = 1; b = 0; code = 4'h5; end
        else if (firstAfterTrap && nTraps == 3) begin f = 1; b = 1; code = 4'h2; end
        instWord = w; fetchFault = f; fetchBadAddr = b; fetchFaultCode = code;
        nop = (w == NOP_WORD);
        skip = f || b || nop;
        qPc[qWr] = expPc; qSeq[qWr] = seqCnt; qFlt[qWr] = f || b;
        qCode[qWr] = b ? MCHK : code; qNop[qWr] = nop; qBad[qWr] = b;
        qExp[qWr] = maxi(readyCycle(cyc, skip), lastExp + 1);
        // directed exact-latency expectations from an empty queue
        if (firstAfterReset)
          chk(qExp[qWr] == cyc + 1, "R8 nop latency model", qExp[qWr], cyc + 1);
        if (firstAfterTrap && nTraps == 1)
          chk(qExp[qWr] == cyc + 1 + EXE_LAT, "R8 ordinary latency model", qExp[qWr], cyc + 1 + EXE_LAT);
        lastExp = qExp[qWr];
        qWr = (qWr + 1) % 16; qSize++; seqCnt++;
        if (f || b) nextBs = B_WAIT;
        else expPc = expPc + 4;
        firstAfterReset = 0; firstAfterTrap = 0;
      end else begin
        instWord = '0; fetchFault = 0; fetchBadAddr = 0; fetchFaultCode = '0;
      end

      if (doTrap) begin
        qSize = 0; qRd = 0; qWr = 0;
        lastExp = 0; expPc = TRAP_VEC;
        nextBs = B_BUB; firstAfterTrap = 1; nTraps++;
      end
      bs = nextBs;
      @(negedge clk);
    end

    chk(nTraps >= 5, "R6 traps taken", nTraps, 5);
    chk(nMchk >= 1, "R4 machine checks seen", nMchk, 1);
    chk(nFull >= 10, "R9 queue reached full", nFull, 10);
    chk(nCommits >= 100, "R10 retire count", nCommits, 100);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule